// File: doc/BRIEF.md
# Eight-Bit Event Timer with Sticky Overflow Flag

This block is a small up-counter for a microcontroller-style peripheral set. It does not run on a clock of its own. It advances by one on each cycle in which an external clock-enable generator pulses the count strobe `cnt_en`. The block drives its 3-bit source-select field out on `src_sel`, and the generator uses that field to choose the strobe rate. A select value of zero means no source, and the counter then holds its value.

Software reaches three registers through a simple port with an address, a write strobe and write data. Read data is combinational. The registers are the counter itself, a control word and a flag word. When the counter wraps from all ones to zero, a sticky overflow flag is set. The flag behaves like a ninth count bit that only hardware can set. It is cleared when software writes a one to it, or when the interrupt controller acknowledges the overflow interrupt. The interrupt request is the overflow flag gated by the local enable bit and by a global enable input.

Register map, at address `reg_addr`: 0 is the counter, 1 is the control word, 2 is the flag word, and 3 is unused and reads zero.

Top module: `tmr_ovf_timer`

## Requirements
- R1: After reset, the counter, control word, flag word and `irq_req` are all zero.
- R2: When the select field is nonzero, each cycle with `cnt_en` high increments the counter by one. Cycles without the strobe leave it unchanged.
- R3: When the select field (control bits [2:0]) is 000, `cnt_en` is ignored and the counter keeps its value.
- R4: On the strobe that takes the counter from 0xFF to 0x00, flag bit 0 at address 2 reads one after the same clock edge that makes the counter read zero.
- R5: Further counting never clears the overflow flag.
- R6: Writing address 2 with bit 0 set clears the flag. Writing it with bit 0 clear has no effect, whatever the other bits are.
- R7: A one-cycle `irq_ack` clears the flag.
- R8: `irq_req` is high exactly when the flag, the interrupt-enable bit (control bit 3) and `glb_irq_en` are all one.
- R9: A counter write in the same cycle as a strobe loads the written value. No increment happens, and no overflow is flagged in that cycle.
- R10: If a flag clear (by write or by acknowledge) and a wrap fall in the same cycle, the flag ends up set.
- R11: The control word holds the select field in bits [2:0] and the enable in bit 3. Bits [7:4] ignore writes and read zero, and address 3 reads zero.
- R12: The counter can be written at any time, and the value written reads back directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | One-cycle count strobe from the clock-enable generator |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Overflow interrupt acknowledge, clears the flag |
| reg_addr | input | 2 | Register address: 0 counter, 1 control, 2 flag |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| src_sel | output | 3 | Select field passed to the clock-enable generator |
| irq_req | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software counter load and a count strobe. The second is a flag clear (by writing a one or by acknowledge) and the wrap that would set the flag. The bench raises both inputs of each pair in one cycle, with the counter preset to 0xFF so that the strobe is a real wrap. It then reads the counter and flag registers back. A load must leave the written value with the flag still clear, and a clear that meets a wrap must leave the flag set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT  = 2'd0,
    REG_CTL  = 2'd1,
    REG_FLG  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W:0]   wdata,
  output logic [SEL_W-1:0] sel,
  output logic             ie
);
  logic [SEL_W-1:0] sel_d, sel_q;
  logic             ie_d, ie_q;

  always_comb begin
    sel_d = sel_q;
    ie_d  = ie_q;
    if (wr) begin
      sel_d = wdata[SEL_W-1:0];
      ie_d  = wdata[SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ie_q  <= ie_d;
    end
  end

  assign sel = sel_q;
  assign ie  = ie_q;

  // R11: control fields take written value and hold otherwise
  assert_ctl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (sel_q == $past(wdata[SEL_W-1:0])) && (ie_q == $past(wdata[SEL_W])));
  assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(sel_q) && $stable(ie_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_d, cnt_q;
  logic         step;

  always_comb begin
    step  = run && cnt_en && !load;
    wrap  = step && (cnt_q == TOP);
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R2: a strobe with a source selected advances by one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && !load) |=> cnt_q == $past(cnt_q) + ONE);
  // R3: no source selected means the value holds
  assert_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
  // R9 / R12: a software load always wins
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R4: a wrap leaves the counter at zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R4 / R10: an overflow always leaves the flag set, even against a clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  // R5: without a clear request the flag never drops
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R6 / R7: a clear with no overflow empties the flag
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/tmr_ovf_timer.sv
module tmr_ovf_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_en,
  input  logic                      glb_irq_en,
  input  logic                      irq_ack,
  input  logic [tmr_pkg::ADDR_W-1:0] reg_addr,
  input  logic                      reg_we,
  input  logic [CNT_W-1:0]          reg_wdata,
  output logic [CNT_W-1:0]          reg_rdata,
  output logic [SEL_W-1:0]          src_sel,
  output logic                      irq_req
);
  import tmr_pkg::*;

  localparam int IE_BIT = SEL_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             we_cnt, we_ctl, we_flg;
  logic [SEL_W-1:0] sel;
  logic             ie;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             flag;
  logic             flag_clr;
  logic [CNT_W-1:0] ctl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    we_cnt   = reg_we && (reg_addr_e'(reg_addr) == REG_CNT);
    we_ctl   = reg_we && (reg_addr_e'(reg_addr) == REG_CTL);
    we_flg   = reg_we && (reg_addr_e'(reg_addr) == REG_FLG);
    flag_clr = (we_flg && reg_wdata[0]) || irq_ack;
  end

  tmr_ctl_reg #(.SEL_W(SEL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (we_ctl),
    .wdata (reg_wdata[SEL_W:0]),
    .sel   (sel),
    .ie    (ie)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (sel != '0),
    .cnt_en   (cnt_en),
    .load     (we_cnt),
    .load_val (reg_wdata),
    .count    (count),
    .wrap     (wrap)
  );

  tmr_ovf_flag u_flg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (wrap),
    .clr   (flag_clr),
    .flag  (flag)
  );

  always_comb begin
    ctl_word                = '0;
    ctl_word[SEL_W-1:0]     = sel;
    ctl_word[IE_BIT]        = ie;
    case (reg_addr_e'(reg_addr))
      REG_CNT: reg_rdata = count;
      REG_CTL: reg_rdata = ctl_word;
      REG_FLG: reg_rdata = {{(CNT_W-1){1'b0}}, flag};
      default: reg_rdata = '0;
    endcase
  end

  assign src_sel = sel;
  assign irq_req = flag && ie && glb_irq_en;

  // R8: the global enable masks the request
  assert_global_mask_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !glb_irq_en |-> !irq_req);
  // R7: an acknowledge without a fresh wrap drops the request
  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack && !wrap) |=> !irq_req);
  // R11: upper control bits always read zero
  assert_ctl_upper_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr_e'(reg_addr) == REG_CTL) |-> (reg_rdata[CNT_W-1:IE_BIT+1] == '0));
endmodule

// File: tb/tb_tmr_ovf_timer.sv
module tb_tmr_ovf_timer;
  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic       glb_irq_en;
  logic       irq_ack;
  logic [1:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [2:0] src_sel;
  logic       irq_req;

  int compared;
  int mismatched;
  bit done;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] item;
  string      item_tag;
  logic [7:0] actual;

  tmr_ovf_timer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .glb_irq_en (glb_irq_en),
    .irq_ack    (irq_ack),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .src_sel    (src_sel),
    .irq_req    (irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops one expected item per falling edge and compares it
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item     = exp_q.pop_front();
      item_tag = tag_q.pop_front();
      actual   = item[8] ? {7'b0, irq_req} : reg_rdata;
      compared++;
      if (actual !== item[7:0]) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h", item_tag, actual, item[7:0]);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    reg_addr = a;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic exp_irq(input logic e, input string t);
    exp_q.push_back({1'b1, 7'b0, e});
    tag_q.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; cnt_en = 1'b1;
    cyc();
    reg_we = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_en = 1'b1;
      cyc();
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; glb_irq_en = 1'b0; irq_ack = 1'b0;
    reg_addr = 2'd0; reg_we = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) cyc();

    exp_rd(2'd0, 8'h00, "R1 counter");
    exp_rd(2'd1, 8'h00, "R1 control");
    exp_rd(2'd2, 8'h00, "R1 flag");
    exp_irq(1'b0, "R1 irq");

    ticks(5);
    exp_rd(2'd0, 8'h00, "R3 select 000 ignores strobe");

    wr(2'd1, 8'hF9);
    exp_rd(2'd1, 8'h09, "R11 upper control bits dropped");
    exp_rd(2'd3, 8'h00, "R11 unused address");

    ticks(3);
    exp_rd(2'd0, 8'h03, "R2 three strobes");
    repeat (4) cyc();
    exp_rd(2'd0, 8'h03, "R2 idle cycles hold");

    wr(2'd0, 8'hFD);
    exp_rd(2'd0, 8'hFD, "R12 counter load");
    ticks(2);
    exp_rd(2'd0, 8'hFF, "R2 reach top");
    exp_rd(2'd2, 8'h00, "R4 no flag before wrap");
    ticks(1);
    exp_rd(2'd0, 8'h00, "R4 wrapped to zero");
    exp_rd(2'd2, 8'h01, "R4 flag on wrap");

    exp_irq(1'b0, "R8 global off");
    glb_irq_en = 1'b1;
    exp_irq(1'b1, "R8 all enabled");
    wr(2'd1, 8'h01);
    exp_irq(1'b0, "R8 local enable off");
    wr(2'd1, 8'h09);
    exp_irq(1'b1, "R8 local enable back on");

    ticks(3);
    exp_rd(2'd2, 8'h01, "R5 flag survives counting");
    exp_rd(2'd0, 8'h03, "R5 counter after wrap");

    wr(2'd2, 8'h00);
    exp_rd(2'd2, 8'h01, "R6 write zero no effect");
    wr(2'd2, 8'hFE);
    exp_rd(2'd2, 8'h01, "R6 bit0 clear no effect");
    wr(2'd2, 8'h01);
    exp_rd(2'd2, 8'h00, "R6 write one clears");
    exp_irq(1'b0, "R6 request gone");

    wr_tick(2'd0, 8'h40);
    exp_rd(2'd0, 8'h40, "R9 load beats strobe");
    wr(2'd0, 8'hFF);
    wr_tick(2'd0, 8'h10);
    exp_rd(2'd0, 8'h10, "R9 load at top");
    exp_rd(2'd2, 8'h00, "R9 no overflow on load");

    wr(2'd0, 8'hFF);
    ticks(1);
    exp_irq(1'b1, "R7 request before ack");
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
    exp_rd(2'd2, 8'h00, "R7 ack clears flag");
    exp_irq(1'b0, "R7 request after ack");

    wr(2'd0, 8'hFF);
    wr_tick(2'd2, 8'h01);
    exp_rd(2'd2, 8'h01, "R10 write clear meets wrap");
    exp_rd(2'd0, 8'h00, "R10 counter wrapped");

    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h01);
    exp_rd(2'd2, 8'h00, "R10 flag cleared first");
    cnt_en = 1'b1; irq_ack = 1'b1;
    cyc();
    cnt_en = 1'b0; irq_ack = 1'b0;
    exp_rd(2'd2, 8'h01, "R10 ack meets wrap");
    exp_irq(1'b1, "R10 request stays");

    wr(2'd1, 8'h08);
    wr(2'd0, 8'h55);
    ticks(4);
    exp_rd(2'd0, 8'h55, "R3 stopped after select cleared");
    exp_rd(2'd1, 8'h08, "R11 enable alone");

    wr(2'd1, 8'h05);
    ticks(2);
    exp_rd(2'd0, 8'h57, "R2 other select value");

    while (exp_q.size() > 0) @(negedge clk);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule